// File: doc/BRIEF.md
# AXI Bridge Transaction Error Monitor

This block sits beside one port of an AXI bridge and observes its traffic without taking part in it. Each accepted read or write address command is checked in two ways. It is compared against a four-entry programmable address window table, and it is tested against burst legality rules: FIXED bursts, non-modifiable WRAP, a WRAP that does not cover exactly one cache line, and transfers narrower than the data bus. The response channels are watched for error codes. A per-channel timer flags a response that is overdue. Overflow pulses from external capture counters, a power-gated-layer hit and a port-check error are also collected.

All events feed one 64-bit sticky status word that records only the first error event. When several events arrive in the same cycle they are captured together. After that, nothing more is recorded until software has cleared every set bit by writing zeros through a simple write port. A command that misses the table also raises a same-cycle indication, which the bridge uses to answer the command locally with a decode error.

Top module: `axbe_err_monitor`

## Requirements
- R1: An accepted address command whose address matches no table entry sets status bit 0 (read) or bit 16 (write), and raises `ar_local_err`/`aw_local_err` in the same cycle as the handshake. An entry matches when `(addr ^ base) & mask == 0`.
- R2: An accepted command whose address matches two or more entries sets bit 5 (read) or bit 21 (write).
- R3: An accepted command with burst code 0 (FIXED) sets bit 4 (read) or bit 20 (write).
- R4: An accepted command with burst code 2 (WRAP) and cache bit 0 low sets bit 3 (read) or bit 19 (write).
- R5: A WRAP command with (len+1)·2^size bytes not equal to 64 sets bit 7 or bit 23. Any command with 2^size below 8 bytes sets bit 8 or bit 24.
- R6: A response beat with code 2 (SLVERR) sets bit 2 (read) or bit 18 (write). Code 3 (DECERR) sets bit 1 or bit 17.
- R7: With the timeout enabled and limit L, a command with no completing response (R with last, or B) sets bit 6 or bit 22 after the clock edge L+1 cycles after the address handshake. With the timeout disabled, nothing is set.
- R8: Pulses on `cnt0_ovf`, `cnt1_ovf`, `gated_hit` and `portchk_err` set bits 32, 33, 34 and 40. All other bits always read zero.
- R9: While any status bit is set, new events are ignored. Events arriving in the same cycle while the status is clear are all latched together.
- R10: A register write replaces the status with status AND write data, so writing 1 keeps a bit and writing 0 clears it. A write takes precedence over events in the same cycle, and reset leaves the status at zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_base | input | N_ENT*AW | Window base addresses, entry i at bits i*AW |
| cfg_mask | input | N_ENT*AW | Window compare masks, 1 = bit compared |
| cfg_to_en | input | 1 | Response timeout enable |
| cfg_to_limit | input | TO_W | Timeout limit in cycles |
| ar_valid | input | 1 | Read address valid |
| ar_ready | input | 1 | Read address ready |
| ar_addr | input | AW | Read address |
| ar_burst | input | 2 | Read burst type |
| ar_size | input | 3 | Read beat size code |
| ar_len | input | 8 | Read beat count minus one |
| ar_cache | input | 4 | Read cache attributes |
| aw_valid | input | 1 | Write address valid |
| aw_ready | input | 1 | Write address ready |
| aw_addr | input | AW | Write address |
| aw_burst | input | 2 | Write burst type |
| aw_size | input | 3 | Write beat size code |
| aw_len | input | 8 | Write beat count minus one |
| aw_cache | input | 4 | Write cache attributes |
| r_valid | input | 1 | Read data valid |
| r_ready | input | 1 | Read data ready |
| r_resp | input | 2 | Read response code |
| r_last | input | 1 | Last read beat |
| b_valid | input | 1 | Write response valid |
| b_ready | input | 1 | Write response ready |
| b_resp | input | 2 | Write response code |
| cnt0_ovf | input | 1 | Capture counter 0 overflow pulse |
| cnt1_ovf | input | 1 | Capture counter 1 overflow pulse |
| gated_hit | input | 1 | Traffic to a power-gated layer |
| portchk_err | input | 1 | Port-check error pulse |
| csr_wr | input | 1 | Status register write strobe |
| csr_wdata | input | 64 | Status register write data |
| status | output | 64 | Sticky first-error status |
| ar_local_err | output | 1 | Read command missed the table this cycle |
| aw_local_err | output | 1 | Write command missed the table this cycle |

## Verification
Command, response and side-input events are combinational up to the status register. Each one is therefore visible in `status` right after the clock edge that accepts the handshake or pulse. The bench drives on the falling edge and checks at the next falling edge. The local-miss flags are combinational and are sampled one time unit after they are driven, before that edge. A timeout appears only after the edge L+1 cycles past the handshake edge. The bench therefore checks for zero after L edges and for the bit after one more.

// File: rtl/axbe_pkg.sv
package axbe_pkg;
   localparam int STATUS_W   = 64;
   localparam int CH_ERR_W   = 9;
   localparam int WR_OFFSET  = 16;

   localparam int CE_LOCAL_DEC  = 0;
   localparam int CE_SLV_DEC    = 1;
   localparam int CE_SLV_ERR    = 2;
   localparam int CE_NONMOD_WRP = 3;
   localparam int CE_FIXED      = 4;
   localparam int CE_MULTI      = 5;
   localparam int CE_TIMEOUT    = 6;
   localparam int CE_WRAP_SIZE  = 7;
   localparam int CE_NARROW     = 8;

   localparam int SE_OVF0    = 32;
   localparam int SE_OVF1    = 33;
   localparam int SE_GATED   = 34;
   localparam int SE_PORTCHK = 40;

   localparam logic [1:0] BURST_FIXED = 2'd0;
   localparam logic [1:0] BURST_INCR  = 2'd1;
   localparam logic [1:0] BURST_WRAP  = 2'd2;

   localparam logic [1:0] RESP_SLVERR = 2'd2;
   localparam logic [1:0] RESP_DECERR = 2'd3;

   typedef logic [CH_ERR_W-1:0] ch_err_t;

   function automatic logic [STATUS_W-1:0] impl_mask();
      logic [STATUS_W-1:0] m;
      m = '0;
      m[CH_ERR_W-1:0]                   = '1;
      m[WR_OFFSET +: CH_ERR_W]          = '1;
      m[SE_OVF0]    = 1'b1;
      m[SE_OVF1]    = 1'b1;
      m[SE_GATED]   = 1'b1;
      m[SE_PORTCHK] = 1'b1;
      return m;
   endfunction
endpackage

// File: rtl/axbe_addr_match.sv
module axbe_addr_match #(
   parameter int AW    = 32,
   parameter int N_ENT = 4
) (
   input  logic [AW-1:0]       addr,
   input  logic [N_ENT*AW-1:0] base,
   input  logic [N_ENT*AW-1:0] mask,
   output logic                hit_none,
   output logic                hit_multi
);
   logic [N_ENT-1:0] hits;

   for (genvar i = 0; i < N_ENT; i++) begin : g_ent
      assign hits[i] = ((addr ^ base[i*AW +: AW]) & mask[i*AW +: AW]) == '0;
   end

   assign hit_none  = (hits == '0);
   assign hit_multi = ((hits & (hits - 1'b1)) != '0);
endmodule

// File: rtl/axbe_cmd_check.sv
module axbe_cmd_check
   import axbe_pkg::*;
#(
   parameter int AW         = 32,
   parameter int N_ENT      = 4,
   parameter int LINE_BYTES = 64,
   parameter int BUS_BYTES  = 8
) (
   input  logic                hs,
   input  logic [AW-1:0]       addr,
   input  logic [1:0]          burst,
   input  logic [2:0]          size,
   input  logic [7:0]          len,
   input  logic [3:0]          cache,
   input  logic [N_ENT*AW-1:0] base,
   input  logic [N_ENT*AW-1:0] mask,
   output ch_err_t             err,
   output logic                local_miss
);
   localparam int TOT_W = 16;
   localparam logic [TOT_W-1:0] LINE_V = TOT_W'(LINE_BYTES);
   localparam logic [TOT_W-1:0] BUS_V  = TOT_W'(BUS_BYTES);

   logic             miss, multi;
   logic [TOT_W-1:0] beat_bytes, total_bytes;
   logic             is_wrap;

   axbe_addr_match #(.AW(AW), .N_ENT(N_ENT)) u_match (
      .addr      (addr),
      .base      (base),
      .mask      (mask),
      .hit_none  (miss),
      .hit_multi (multi)
   );

   assign beat_bytes  = TOT_W'(1) << size;
   assign total_bytes = (TOT_W'(len) + TOT_W'(1)) << size;
   assign is_wrap     = (burst == BURST_WRAP);

   always_comb begin
      err                = '0;
      err[CE_LOCAL_DEC]  = hs && miss;
      err[CE_MULTI]      = hs && multi;
      err[CE_FIXED]      = hs && (burst == BURST_FIXED);
      err[CE_NONMOD_WRP] = hs && is_wrap && !cache[0];
      err[CE_WRAP_SIZE]  = hs && is_wrap && (total_bytes != LINE_V);
      err[CE_NARROW]     = hs && (beat_bytes < BUS_V);
   end

   assign local_miss = hs && miss;
endmodule

// File: rtl/axbe_resp_track.sv
module axbe_resp_track
   import axbe_pkg::*;
#(
   parameter int TO_W = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            cmd_hs,
   input  logic            rsp_hs,
   input  logic            rsp_last,
   input  logic [1:0]      rsp_code,
   input  logic            to_en,
   input  logic [TO_W-1:0] to_limit,
   output logic            err_slv,
   output logic            err_dec,
   output logic            err_to
);
   logic            busy, fired;
   logic [TO_W-1:0] cnt;

   assign err_slv = rsp_hs && (rsp_code == RESP_SLVERR);
   assign err_dec = rsp_hs && (rsp_code == RESP_DECERR);
   assign err_to  = busy && to_en && !fired && (cnt == to_limit);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         busy  <= 1'b0;
         fired <= 1'b0;
         cnt   <= '0;
      end else if (cmd_hs) begin
         busy  <= 1'b1;
         fired <= 1'b0;
         cnt   <= '0;
      end else if (rsp_hs && rsp_last) begin
         busy  <= 1'b0;
      end else if (busy && to_en && !fired) begin
         if (cnt == to_limit) fired <= 1'b1;
         else                 cnt   <= cnt + 1'b1;
      end
   end
endmodule

// File: rtl/axbe_status_reg.sv
module axbe_status_reg
   import axbe_pkg::*;
(
   input  logic                clk,
   input  logic                rst_n,
   input  logic [STATUS_W-1:0] ev,
   input  logic                wr,
   input  logic [STATUS_W-1:0] wdata,
   output logic [STATUS_W-1:0] status
);
   localparam logic [STATUS_W-1:0] IMPL = impl_mask();

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 status <= '0;
      else if (wr)                status <= status & wdata;
      else if (status == '0)      status <= ev & IMPL;
   end
endmodule

// File: rtl/axbe_err_monitor.sv
module axbe_err_monitor
   import axbe_pkg::*;
#(
   parameter int AW         = 32,
   parameter int N_ENT      = 4,
   parameter int LINE_BYTES = 64,
   parameter int BUS_BYTES  = 8,
   parameter int TO_W       = 16
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic [N_ENT*AW-1:0] cfg_base,
   input  logic [N_ENT*AW-1:0] cfg_mask,
   input  logic                cfg_to_en,
   input  logic [TO_W-1:0]     cfg_to_limit,
   input  logic                ar_valid,
   input  logic                ar_ready,
   input  logic [AW-1:0]       ar_addr,
   input  logic [1:0]          ar_burst,
   input  logic [2:0]          ar_size,
   input  logic [7:0]          ar_len,
   input  logic [3:0]          ar_cache,
   input  logic                aw_valid,
   input  logic                aw_ready,
   input  logic [AW-1:0]       aw_addr,
   input  logic [1:0]          aw_burst,
   input  logic [2:0]          aw_size,
   input  logic [7:0]          aw_len,
   input  logic [3:0]          aw_cache,
   input  logic                r_valid,
   input  logic                r_ready,
   input  logic [1:0]          r_resp,
   input  logic                r_last,
   input  logic                b_valid,
   input  logic                b_ready,
   input  logic [1:0]          b_resp,
   input  logic                cnt0_ovf,
   input  logic                cnt1_ovf,
   input  logic                gated_hit,
   input  logic                portchk_err,
   input  logic                csr_wr,
   input  logic [63:0]         csr_wdata,
   output logic [63:0]         status,
   output logic                ar_local_err,
   output logic                aw_local_err
);
   localparam int N_CH = 2;

   if (N_ENT < 1 || N_ENT > 32) begin : g_bad_ent
      $error("N_ENT out of range");
   end
   if (BUS_BYTES < 1 || (BUS_BYTES & (BUS_BYTES - 1)) != 0) begin : g_bad_bus
      $error("BUS_BYTES must be a power of two");
   end
   if (LINE_BYTES < BUS_BYTES || LINE_BYTES > 32768) begin : g_bad_line
      $error("LINE_BYTES out of range");
   end
   if (TO_W < 2 || TO_W > 32) begin : g_bad_to
      $error("TO_W out of range");
   end

   logic [N_CH-1:0]          c_hs, c_rhs, c_rlast, c_miss;
   logic [N_CH-1:0][AW-1:0]  c_addr;
   logic [N_CH-1:0][1:0]     c_burst, c_rcode;
   logic [N_CH-1:0][2:0]     c_size;
   logic [N_CH-1:0][7:0]     c_len;
   logic [N_CH-1:0][3:0]     c_cache;
   ch_err_t [N_CH-1:0]       ch_err;
   logic [STATUS_W-1:0]      ev;

   assign c_hs    = {aw_valid && aw_ready, ar_valid && ar_ready};
   assign c_addr  = {aw_addr, ar_addr};
   assign c_burst = {aw_burst, ar_burst};
   assign c_size  = {aw_size, ar_size};
   assign c_len   = {aw_len, ar_len};
   assign c_cache = {aw_cache, ar_cache};
   assign c_rhs   = {b_valid && b_ready, r_valid && r_ready};
   assign c_rlast = {1'b1, r_last};
   assign c_rcode = {b_resp, r_resp};

   for (genvar c = 0; c < N_CH; c++) begin : g_ch
      ch_err_t cmd_err, rsp_err;
      logic    slv, dec, tmo;

      axbe_cmd_check #(
         .AW(AW), .N_ENT(N_ENT), .LINE_BYTES(LINE_BYTES), .BUS_BYTES(BUS_BYTES)
      ) u_cmd (
         .hs         (c_hs[c]),
         .addr       (c_addr[c]),
         .burst      (c_burst[c]),
         .size       (c_size[c]),
         .len        (c_len[c]),
         .cache      (c_cache[c]),
         .base       (cfg_base),
         .mask       (cfg_mask),
         .err        (cmd_err),
         .local_miss (c_miss[c])
      );

      axbe_resp_track #(.TO_W(TO_W)) u_rsp (
         .clk      (clk),
         .rst_n    (rst_n),
         .cmd_hs   (c_hs[c]),
         .rsp_hs   (c_rhs[c]),
         .rsp_last (c_rlast[c]),
         .rsp_code (c_rcode[c]),
         .to_en    (cfg_to_en),
         .to_limit (cfg_to_limit),
         .err_slv  (slv),
         .err_dec  (dec),
         .err_to   (tmo)
      );

      always_comb begin
         rsp_err             = '0;
         rsp_err[CE_SLV_ERR] = slv;
         rsp_err[CE_SLV_DEC] = dec;
         rsp_err[CE_TIMEOUT] = tmo;
      end

      assign ch_err[c] = cmd_err | rsp_err;
   end

   always_comb begin
      ev = '0;
      for (int c = 0; c < N_CH; c++) ev[c*WR_OFFSET +: CH_ERR_W] = ch_err[c];
      ev[SE_OVF0]    = cnt0_ovf;
      ev[SE_OVF1]    = cnt1_ovf;
      ev[SE_GATED]   = gated_hit;
      ev[SE_PORTCHK] = portchk_err;
   end

   axbe_status_reg u_stat (
      .clk    (clk),
      .rst_n  (rst_n),
      .ev     (ev),
      .wr     (csr_wr),
      .wdata  (csr_wdata),
      .status (status)
   );

   assign ar_local_err = c_miss[0];
   assign aw_local_err = c_miss[1];
endmodule

// File: rtl/axbe_err_checker.sv
module axbe_err_checker
   import axbe_pkg::*;
(
   input logic        clk,
   input logic        rst_n,
   input logic        ar_valid,
   input logic        ar_ready,
   input logic [1:0]  ar_burst,
   input logic        ar_local_err,
   input logic        cnt0_ovf,
   input logic        csr_wr,
   input logic [63:0] csr_wdata,
   input logic [63:0] status
);
   localparam logic [63:0] IMPL = impl_mask();

   p_reset_zero_r10: assert property (@(posedge clk) !rst_n |=> status == '0);

   p_unused_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (status & ~IMPL) == '0);

   p_hold_first_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (status != '0 && !csr_wr) |=> status == $past(status));

   p_write_and_r10: assert property (@(posedge clk) disable iff (!rst_n)
      csr_wr |=> status == ($past(status) & $past(csr_wdata)));

   p_fixed_latch_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_valid && ar_ready && ar_burst == BURST_FIXED && status == '0 && !csr_wr)
      |=> status[CE_FIXED]);

   p_miss_latch_r1: assert property (@(posedge clk) disable iff (!rst_n)
      (ar_local_err && status == '0 && !csr_wr) |=> status[CE_LOCAL_DEC]);

   p_ovf_latch_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt0_ovf && status == '0 && !csr_wr) |=> status[SE_OVF0]);
endmodule

bind axbe_err_monitor axbe_err_checker u_err_checker (
   .clk          (clk),
   .rst_n        (rst_n),
   .ar_valid     (ar_valid),
   .ar_ready     (ar_ready),
   .ar_burst     (ar_burst),
   .ar_local_err (ar_local_err),
   .cnt0_ovf     (cnt0_ovf),
   .csr_wr       (csr_wr),
   .csr_wdata    (csr_wdata),
   .status       (status)
);

// File: tb/test_axbe_err_monitor.sv
module test_axbe_err_monitor;
   localparam int CLK_PERIOD = 10;
   localparam int AW = 32;
   localparam int N_ENT = 4;
   localparam int TO_W = 16;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [N_ENT*AW-1:0] cfg_base, cfg_mask;
   logic cfg_to_en = 1'b0;
   logic [TO_W-1:0] cfg_to_limit = '0;
   logic ar_valid = 0, ar_ready = 0, aw_valid = 0, aw_ready = 0;
   logic [AW-1:0] ar_addr = '0, aw_addr = '0;
   logic [1:0] ar_burst = 0, aw_burst = 0;
   logic [2:0] ar_size = 0, aw_size = 0;
   logic [7:0] ar_len = 0, aw_len = 0;
   logic [3:0] ar_cache = 0, aw_cache = 0;
   logic r_valid = 0, r_ready = 0, r_last = 0, b_valid = 0, b_ready = 0;
   logic [1:0] r_resp = 0, b_resp = 0;
   logic cnt0_ovf = 0, cnt1_ovf = 0, gated_hit = 0, portchk_err = 0;
   logic csr_wr = 0;
   logic [63:0] csr_wdata = '0;
   logic [63:0] status;
   logic ar_local_err, aw_local_err;

   int n_checks = 0;
   int n_errors = 0;
   logic lerr_seen;

   always #(CLK_PERIOD/2) clk = ~clk;

   axbe_err_monitor i_axbe_err_monitor (.*);

   localparam logic [AW-1:0] A_GOOD  = 32'h1000_0040;
   localparam logic [AW-1:0] A_MISS  = 32'h8000_0000;
   localparam logic [AW-1:0] A_MULTI = 32'h2000_0100;

   task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_checks++;
      if (act !== exp) begin
         n_errors++;
         $display("FAIL %s: actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic clear_all();
      @(negedge clk); csr_wr = 1; csr_wdata = '0;
      @(negedge clk); csr_wr = 0;
   endtask

   task automatic cmd(input bit wr, input logic [AW-1:0] a, input logic [1:0] bu,
                      input logic [2:0] sz, input logic [7:0] ln, input logic [3:0] ca);
      @(negedge clk);
      if (wr) begin
         aw_valid = 1; aw_ready = 1; aw_addr = a; aw_burst = bu; aw_size = sz; aw_len = ln; aw_cache = ca;
      end else begin
         ar_valid = 1; ar_ready = 1; ar_addr = a; ar_burst = bu; ar_size = sz; ar_len = ln; ar_cache = ca;
      end
      #1 lerr_seen = wr ? aw_local_err : ar_local_err;
      @(negedge clk);
      ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0;
   endtask

   task automatic t_reset();
      check("R10 reset", status, 64'h0);
      check("R10 reset flags", {62'h0, ar_local_err, aw_local_err}, 64'h0);
   endtask

   task automatic t_miss();
      cmd(0, A_MISS, 2'd1, 3'd3, 8'd7, 4'h3);
      check("R1 read miss flag", {63'h0, lerr_seen}, 64'h1);
      check("R1 read miss bit", status, 64'h1 << 0);
      clear_all();
      cmd(1, A_MISS, 2'd1, 3'd3, 8'd7, 4'h3);
      check("R1 write miss flag", {63'h0, lerr_seen}, 64'h1);
      check("R1 write miss bit", status, 64'h1 << 16);
      clear_all();
      cmd(0, A_GOOD, 2'd1, 3'd3, 8'd7, 4'h3);
      check("R1 clean command flag", {63'h0, lerr_seen}, 64'h0);
      check("R1 clean command no error", status, 64'h0);
   endtask

   task automatic t_multi();
      cmd(0, A_MULTI, 2'd1, 3'd3, 8'd0, 4'h3);
      check("R2 read multi-hit", status, 64'h1 << 5);
      clear_all();
      cmd(1, A_MULTI, 2'd1, 3'd3, 8'd0, 4'h3);
      check("R2 write multi-hit", status, 64'h1 << 21);
      clear_all();
   endtask

   task automatic t_fixed();
      cmd(0, A_GOOD, 2'd0, 3'd3, 8'd0, 4'h3);
      check("R3 read fixed", status, 64'h1 << 4);
      clear_all();
      cmd(1, A_GOOD, 2'd0, 3'd3, 8'd0, 4'h3);
      check("R3 write fixed", status, 64'h1 << 20);
      clear_all();
   endtask

   task automatic t_nonmod();
      cmd(0, A_GOOD, 2'd2, 3'd3, 8'd7, 4'h2);
      check("R4 read nonmod wrap", status, 64'h1 << 3);
      clear_all();
      cmd(1, A_GOOD, 2'd2, 3'd3, 8'd7, 4'h0);
      check("R4 write nonmod wrap", status, 64'h1 << 19);
      clear_all();
      cmd(0, A_GOOD, 2'd2, 3'd3, 8'd7, 4'h1);
      check("R4 legal wrap no error", status, 64'h0);
   endtask

   task automatic t_size();
      cmd(0, A_GOOD, 2'd2, 3'd3, 8'd3, 4'h1);
      check("R5 read wrap 32B", status, 64'h1 << 7);
      clear_all();
      cmd(1, A_GOOD, 2'd2, 3'd3, 8'd15, 4'h1);
      check("R5 write wrap 128B", status, 64'h1 << 23);
      clear_all();
      cmd(0, A_GOOD, 2'd1, 3'd2, 8'd3, 4'h1);
      check("R5 read narrow", status, 64'h1 << 8);
      clear_all();
      cmd(1, A_GOOD, 2'd2, 3'd2, 8'd15, 4'h1);
      check("R5 write narrow 64B wrap", status, 64'h1 << 24);
      clear_all();
   endtask

   task automatic t_resp();
      @(negedge clk); r_valid = 1; r_ready = 1; r_resp = 2'd2; r_last = 1;
      @(negedge clk); r_valid = 0; r_ready = 0; r_resp = 0;
      check("R6 read slverr", status, 64'h1 << 2);
      clear_all();
      @(negedge clk); b_valid = 1; b_ready = 1; b_resp = 2'd3;
      @(negedge clk); b_valid = 0; b_ready = 0; b_resp = 0;
      check("R6 write decerr", status, 64'h1 << 17);
      clear_all();
      @(negedge clk); r_valid = 1; r_ready = 0; r_resp = 2'd2;
      @(negedge clk); r_valid = 0; r_resp = 0;
      check("R6 no handshake no error", status, 64'h0);
   endtask

   task automatic t_timeout();
      cfg_to_en = 1; cfg_to_limit = 16'd5;
      cmd(0, A_GOOD, 2'd1, 3'd3, 8'd7, 4'h3);
      repeat (5) @(negedge clk);
      check("R7 read not yet timed out", status, 64'h0);
      @(negedge clk);
      check("R7 read timeout", status, 64'h1 << 6);
      @(negedge clk); r_valid = 1; r_ready = 1; r_last = 1;
      @(negedge clk); r_valid = 0; r_ready = 0; r_last = 0;
      clear_all();
      cmd(1, A_GOOD, 2'd1, 3'd3, 8'd7, 4'h3);
      repeat (6) @(negedge clk);
      check("R7 write timeout", status, 64'h1 << 22);
      @(negedge clk); b_valid = 1; b_ready = 1;
      @(negedge clk); b_valid = 0; b_ready = 0;
      clear_all();
      cfg_to_en = 0;
      cmd(0, A_GOOD, 2'd1, 3'd3, 8'd7, 4'h3);
      repeat (10) @(negedge clk);
      check("R7 disabled no timeout", status, 64'h0);
      @(negedge clk); r_valid = 1; r_ready = 1; r_last = 1;
      @(negedge clk); r_valid = 0; r_ready = 0; r_last = 0;
   endtask

   task automatic t_side();
      @(negedge clk); cnt0_ovf = 1;
      @(negedge clk); cnt0_ovf = 0;
      check("R8 counter0 overflow", status, 64'h1 << 32);
      clear_all();
      @(negedge clk); cnt1_ovf = 1; gated_hit = 1; portchk_err = 1;
      @(negedge clk); cnt1_ovf = 0; gated_hit = 0; portchk_err = 0;
      check("R8 side inputs", status, (64'h1 << 33) | (64'h1 << 34) | (64'h1 << 40));
      @(negedge clk); csr_wr = 1; csr_wdata = '1;
      @(negedge clk); csr_wr = 0;
      check("R8 unused stay zero after ones write", status,
            (64'h1 << 33) | (64'h1 << 34) | (64'h1 << 40));
      clear_all();
   endtask

   task automatic t_first();
      cmd(0, A_GOOD, 2'd0, 3'd3, 8'd0, 4'h3);
      cmd(0, A_MISS, 2'd1, 3'd3, 8'd7, 4'h3);
      @(negedge clk); cnt1_ovf = 1;
      @(negedge clk); cnt1_ovf = 0;
      check("R9 later events ignored", status, 64'h1 << 4);
      clear_all();
      @(negedge clk);
      ar_valid = 1; ar_ready = 1; ar_addr = A_GOOD; ar_burst = 2'd0; ar_size = 3'd3; ar_len = 0; ar_cache = 4'h3;
      aw_valid = 1; aw_ready = 1; aw_addr = A_MISS; aw_burst = 2'd1; aw_size = 3'd3; aw_len = 7; aw_cache = 4'h3;
      cnt0_ovf = 1;
      @(negedge clk);
      ar_valid = 0; ar_ready = 0; aw_valid = 0; aw_ready = 0; cnt0_ovf = 0;
      check("R9 same-cycle events together", status,
            (64'h1 << 4) | (64'h1 << 16) | (64'h1 << 32));
   endtask

   task automatic t_write();
      @(negedge clk); csr_wr = 1; csr_wdata = ~(64'h1 << 16);
      @(negedge clk); csr_wr = 0;
      check("R10 partial clear keeps ones", status, (64'h1 << 4) | (64'h1 << 32));
      @(negedge clk); cnt0_ovf = 1;
      @(negedge clk); cnt0_ovf = 0;
      check("R10 nonzero still holds", status, (64'h1 << 4) | (64'h1 << 32));
      @(negedge clk); csr_wr = 1; csr_wdata = '0; cnt1_ovf = 1;
      @(negedge clk); csr_wr = 0; cnt1_ovf = 0;
      check("R10 write wins over event", status, 64'h0);
      @(negedge clk);
      check("R10 cleared stays clear", status, 64'h0);
   endtask

   initial begin
      #(CLK_PERIOD * 50000);
      n_checks++; n_errors++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end

   initial begin
      cfg_base = {32'h2000_0000, 32'h2000_0000, 32'h1000_0000, 32'h0000_0000};
      cfg_mask = {32'hFF00_0000, 32'hF000_0000, 32'hF000_0000, 32'hF000_0000};
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1;
      @(negedge clk);
      t_reset();
      t_miss();
      t_multi();
      t_fixed();
      t_nonmod();
      t_size();
      t_resp();
      t_timeout();
      t_side();
      t_first();
      t_write();
      $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
      $finish;
   end
endmodule